// File: doc/BRIEF.md
# Stream Link Protocol Monitor

This block sits beside a single point-to-point streaming link (valid/ready handshake with byte-qualified data) and watches it without ever driving it. Every cycle it samples the handshake pair, the data bytes, the per-byte keep and strobe masks, the end-of-packet marker, the source and destination tags and the user sideband. From these it detects four classes of protocol breakage: valid withdrawn before acceptance, payload altered while the sink stalls, an illegal keep/strobe pair on some byte, and a tag change inside a packet.

Each class has its own sticky flag that a per-class mask bit can disable. A synchronous clear input resets the flags. Two free-running 32-bit counters report accepted transfers and accepted end-of-packet transfers. The data width is set in bytes, and the user sideband carries a parameterised number of bits per byte. Packets are assumed not to interleave on the link.

Flag bit positions: bit 0 = valid dropped, bit 1 = payload changed while stalled, bit 2 = illegal byte qualifier, bit 3 = tag change inside a packet.

Top module: `stream_link_monitor`

## Requirements
- R1: A transfer is counted on `xfer_count` only in a cycle where `s_valid` and `s_ready` are both high. The counter is visible one clock later. Valid rising first, ready rising first, and both rising together are all accepted.
- R2: If `s_valid` is high and `s_ready` low in one cycle, and `s_valid` is low in the next, flag bit 0 sets after that next cycle's edge.
- R3: Raising and lowering `s_ready` while `s_valid` is low sets no flag and counts nothing.
- R4: If any of data, keep, strobe, last, id, dest or user differs from its value in the preceding stalled cycle (valid high, ready low) while valid is still high, flag bit 1 sets. A change after a transfer is accepted sets nothing.
- R5: In a cycle with `s_valid` high, any byte with keep=0 and strobe=1 sets flag bit 2. The pairs keep=1/strobe=1 (data), keep=1/strobe=0 (position) and keep=0/strobe=0 (null) set nothing. Qualifiers are ignored while valid is low.
- R6: A transfer with every keep bit low is legal and counted, with or without `s_last`.
- R7: An accepted transfer whose id or dest differs from the first transfer of the current packet sets flag bit 3. The first accepted transfer after reset, or after an accepted transfer with `s_last`, may carry any id and dest.
- R8: When `err_mask[k]` is 1, flag bit k does not set. Detection of the other classes is unaffected.
- R9: Flags stay set until `err_clear` is high at a clock edge, which zeroes all flags. The clear wins over an error detected in the same cycle. The counters are not affected by the clear.
- R10: `pkt_count` increments by one for each accepted transfer with `s_last` high. Both counters wrap modulo 2^32.
- R11: After reset, flags and both counters read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| s_valid | input | 1 | Observed source valid |
| s_ready | input | 1 | Observed sink ready |
| s_data | input | 8*BYTES | Observed data bytes |
| s_keep | input | BYTES | Observed keep mask |
| s_strb | input | BYTES | Observed strobe mask |
| s_last | input | 1 | Observed end-of-packet marker |
| s_id | input | ID_W | Observed source tag |
| s_dest | input | DEST_W | Observed destination tag |
| s_user | input | BYTES*USER_PER_BYTE | Observed user sideband |
| err_mask | input | 4 | Per-class disable, 1 = class ignored |
| err_clear | input | 1 | Synchronous clear of all flags |
| err_flags | output | 4 | Sticky error flags |
| xfer_count | output | 32 | Accepted transfer count |
| pkt_count | output | 32 | Accepted end-of-packet count |

## Verification
Assertions check the following on every cycle:
- counter stepping against the previous cycle's handshake;
- flag stickiness;
- priority of the clear;
- the silence of masked classes;
- that a drop event only follows a stalled cycle;
- that no tag error follows a packet end.

Only the bench scenarios show that each illegal pattern actually raises its own flag bit, and that the legal patterns raise nothing:
- ready toggling with no valid;
- position and null bytes;
- null transfers with end-of-packet;
- payload changes after acceptance;
- new tags at a packet boundary.

// File: rtl/stream_mon_pkg.sv
package stream_mon_pkg;
  localparam int ERR_N    = 4;
  localparam int ERR_DROP = 0;
  localparam int ERR_HOLD = 1;
  localparam int ERR_QUAL = 2;
  localparam int ERR_TAG  = 3;
  localparam int CNT_W    = 32;
endpackage

// File: rtl/stream_hs_tracker.sv
module stream_hs_tracker #(
  parameter int PAYLOAD_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 valid,
  input  logic                 ready,
  input  logic [PAYLOAD_W-1:0] payload,
  output logic                 ev_drop,
  output logic                 ev_hold
);
  logic                 stall_q, stall_d;
  logic [PAYLOAD_W-1:0] snap_q, snap_d;
  logic                 stall_now;

  always_comb begin
    stall_now = valid && !ready;
    stall_d   = stall_now;
    snap_d    = stall_now ? payload : snap_q;
    ev_drop   = stall_q && !valid;
    ev_hold   = stall_q && valid && (payload != snap_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stall_q <= 1'b0;
      snap_q  <= '0;
    end else begin
      stall_q <= stall_d;
      snap_q  <= snap_d;
    end
  end

  // R2: a drop is only reported right after a stalled cycle
  a_r2_drop_after_stall: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && ev_drop) |-> $past(valid && !ready));

  // R4: a hold error only arises while valid is still high
  a_r4_hold_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && ev_hold) |-> ($past(valid) && valid));
endmodule

// File: rtl/stream_qual_check.sv
module stream_qual_check #(
  parameter int BYTES = 4
) (
  input  logic             valid,
  input  logic [BYTES-1:0] keep,
  input  logic [BYTES-1:0] strb,
  output logic             ev_qual
);
  logic [BYTES-1:0] bad_lane;

  for (genvar i = 0; i < BYTES; i++) begin : g_lane
    assign bad_lane[i] = strb[i] && !keep[i];
  end

  assign ev_qual = valid && (|bad_lane);
endmodule

// File: rtl/stream_pkt_tracker.sv
module stream_pkt_tracker
  import stream_mon_pkg::*;
#(
  parameter int ID_W   = 4,
  parameter int DEST_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid,
  input  logic              ready,
  input  logic              last,
  input  logic [ID_W-1:0]   id,
  input  logic [DEST_W-1:0] dest,
  output logic              ev_tag,
  output logic [CNT_W-1:0]  xfer_cnt,
  output logic [CNT_W-1:0]  pkt_cnt
);
  logic              accept;
  logic              in_pkt_q, in_pkt_d;
  logic [ID_W-1:0]   ref_id_q, ref_id_d;
  logic [DEST_W-1:0] ref_dest_q, ref_dest_d;
  logic [CNT_W-1:0]  xfer_q, xfer_d, pkt_q, pkt_d;

  always_comb begin
    accept     = valid && ready;
    in_pkt_d   = in_pkt_q;
    ref_id_d   = ref_id_q;
    ref_dest_d = ref_dest_q;
    xfer_d     = xfer_q;
    pkt_d      = pkt_q;
    if (accept) begin
      in_pkt_d = !last;
      xfer_d   = xfer_q + 32'd1;
      if (!in_pkt_q) begin
        ref_id_d   = id;
        ref_dest_d = dest;
      end
      if (last) pkt_d = pkt_q + 32'd1;
    end
    ev_tag = accept && in_pkt_q && ((id != ref_id_q) || (dest != ref_dest_q));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_pkt_q   <= 1'b0;
      ref_id_q   <= '0;
      ref_dest_q <= '0;
      xfer_q     <= '0;
      pkt_q      <= '0;
    end else begin
      in_pkt_q   <= in_pkt_d;
      ref_id_q   <= ref_id_d;
      ref_dest_q <= ref_dest_d;
      xfer_q     <= xfer_d;
      pkt_q      <= pkt_d;
    end
  end

  assign xfer_cnt = xfer_q;
  assign pkt_cnt  = pkt_q;

  // R1: transfer count steps by one exactly after a handshake cycle
  a_r1_xfer_step: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(valid && ready)) |-> (xfer_q == $past(xfer_q) + 32'd1));
  a_r1_xfer_idle: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(valid && ready)) |-> $stable(xfer_q));

  // R10: packet count steps only on an accepted end-of-packet
  a_r10_pkt_step: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(valid && ready && last)) |-> $stable(pkt_q));

  // R7: the transfer after a packet end is always a packet start
  a_r7_boundary_free: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && ready && last) |=> !ev_tag);
endmodule

// File: rtl/stream_err_reg.sv
module stream_err_reg
  import stream_mon_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ERR_N-1:0] events,
  input  logic [ERR_N-1:0] mask,
  input  logic             clear,
  output logic [ERR_N-1:0] flags
);
  logic [ERR_N-1:0] flags_q, flags_d;

  always_comb begin
    if (clear) flags_d = '0;
    else       flags_d = flags_q | (events & ~mask);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= flags_d;
  end

  assign flags = flags_q;

  // R9: clear has priority and empties every flag
  a_r9_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (flags_q == '0));
  // R9: without clear no flag ever falls
  a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !clear |=> ((flags_q & $past(flags_q)) == $past(flags_q)));

  // R8: a masked class never rises
  for (genvar k = 0; k < ERR_N; k++) begin : g_mask_chk
    a_r8_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(mask[k]) && !$past(flags_q[k])) |-> !flags_q[k]);
  end
endmodule

// File: rtl/stream_link_monitor.sv
module stream_link_monitor
  import stream_mon_pkg::*;
#(
  parameter int BYTES         = 4,
  parameter int USER_PER_BYTE = 1,
  parameter int ID_W          = 4,
  parameter int DEST_W        = 4
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           s_valid,
  input  logic                           s_ready,
  input  logic [8*BYTES-1:0]             s_data,
  input  logic [BYTES-1:0]               s_keep,
  input  logic [BYTES-1:0]               s_strb,
  input  logic                           s_last,
  input  logic [ID_W-1:0]                s_id,
  input  logic [DEST_W-1:0]              s_dest,
  input  logic [BYTES*USER_PER_BYTE-1:0] s_user,
  input  logic [3:0]                     err_mask,
  input  logic                           err_clear,
  output logic [3:0]                     err_flags,
  output logic [31:0]                    xfer_count,
  output logic [31:0]                    pkt_count
);
  localparam int USER_W    = BYTES * USER_PER_BYTE;
  localparam int PAYLOAD_W = 8*BYTES + 2*BYTES + 1 + ID_W + DEST_W + USER_W;

  logic             rst_meta_q, rst_sync_q;
  logic             ev_drop, ev_hold, ev_qual, ev_tag;
  logic [ERR_N-1:0] events;
  logic [PAYLOAD_W-1:0] payload;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  assign payload = {s_data, s_keep, s_strb, s_last, s_id, s_dest, s_user};

  stream_hs_tracker #(.PAYLOAD_W(PAYLOAD_W)) u_hs (
    .clk     (clk),
    .rst_n   (rst_sync_q),
    .valid   (s_valid),
    .ready   (s_ready),
    .payload (payload),
    .ev_drop (ev_drop),
    .ev_hold (ev_hold)
  );

  stream_qual_check #(.BYTES(BYTES)) u_qual (
    .valid   (s_valid),
    .keep    (s_keep),
    .strb    (s_strb),
    .ev_qual (ev_qual)
  );

  stream_pkt_tracker #(.ID_W(ID_W), .DEST_W(DEST_W)) u_pkt (
    .clk      (clk),
    .rst_n    (rst_sync_q),
    .valid    (s_valid),
    .ready    (s_ready),
    .last     (s_last),
    .id       (s_id),
    .dest     (s_dest),
    .ev_tag   (ev_tag),
    .xfer_cnt (xfer_count),
    .pkt_cnt  (pkt_count)
  );

  always_comb begin
    events           = '0;
    events[ERR_DROP] = ev_drop;
    events[ERR_HOLD] = ev_hold;
    events[ERR_QUAL] = ev_qual;
    events[ERR_TAG]  = ev_tag;
  end

  stream_err_reg u_err (
    .clk    (clk),
    .rst_n  (rst_sync_q),
    .events (events),
    .mask   (err_mask),
    .clear  (err_clear),
    .flags  (err_flags)
  );

  // R5: a qualifier error never appears in a cycle without valid
  a_r5_qual_only_valid: assert property (@(posedge clk) disable iff (!rst_sync_q)
    ev_qual |-> s_valid);
endmodule

// File: tb/sim_stream_link_monitor.sv
module sim_stream_link_monitor;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        v = 1'b0, r = 1'b0, l = 1'b0;
  logic [31:0] d = '0;
  logic [3:0]  k = 4'hF, s = 4'hF, id = '0, dst = '0, u = '0;
  logic [3:0]  mask = '0;
  logic        clr = 1'b0;
  logic [3:0]  flags;
  logic [31:0] xc, pc;
  int          n_chk = 0, n_err = 0;
  int          exp_x = 0, exp_p = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  stream_link_monitor u0 (
    .clk(clk), .rst_n(rst_n), .s_valid(v), .s_ready(r), .s_data(d),
    .s_keep(k), .s_strb(s), .s_last(l), .s_id(id), .s_dest(dst), .s_user(u),
    .err_mask(mask), .err_clear(clr), .err_flags(flags),
    .xfer_count(xc), .pkt_count(pc)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string what);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic tick();
    if (v && r) begin
      exp_x++;
      if (l) exp_p++;
    end
    @(negedge clk);
  endtask

  task automatic clear_flags();
    v = 1'b0; r = 1'b0; clr = 1'b1; tick(); clr = 1'b0;
  endtask

  task automatic t_reset();
    chk(flags, 4'h0, "R11 flags after reset");
    chk(xc, 0, "R11 xfer count after reset");
    chk(pc, 0, "R11 pkt count after reset");
  endtask

  task automatic t_handshake();
    clear_flags();
    k = 4'hF; s = 4'hF; l = 1'b0;
    r = 1'b1; tick(); r = 1'b0; tick(); r = 1'b1; tick(); r = 1'b0; tick();
    chk(flags, 4'h0, "R3 ready toggle without valid");
    chk(xc, 0, "R3 no count without valid");
    v = 1'b1; d = 32'h11; tick(); tick();
    r = 1'b1; tick();
    d = 32'h22; tick();
    v = 1'b0; r = 1'b1; tick();
    v = 1'b1; d = 32'h33; l = 1'b1; tick();
    v = 1'b0; r = 1'b0; l = 1'b0; tick();
    chk(xc, exp_x, "R1 transfers with mixed orderings");
    chk(xc, 3, "R1 transfer total");
    chk(flags, 4'h0, "R1 legal handshakes flag nothing");
  endtask

  task automatic t_drop();
    clear_flags();
    v = 1'b1; r = 1'b0; d = 32'h44; l = 1'b1; tick();
    v = 1'b0; tick();
    chk(flags, 4'h1, "R2 valid dropped before accept");
    l = 1'b0;
  endtask

  task automatic t_hold();
    clear_flags();
    v = 1'b1; r = 1'b0; d = 32'hA; l = 1'b1; tick();
    d = 32'hB; tick();
    chk(flags, 4'h2, "R4 data changed during stall");
    r = 1'b1; tick();
    clear_flags();
    v = 1'b1; r = 1'b0; d = 32'hC; u = 4'h0; tick();
    u = 4'h5; tick();
    chk(flags, 4'h2, "R4 user changed during stall");
    r = 1'b1; tick();
    clear_flags();
    v = 1'b1; r = 1'b1; d = 32'hD; tick();
    d = 32'hE; tick();
    v = 1'b0; tick();
    chk(flags, 4'h0, "R4 change after acceptance is legal");
  endtask

  task automatic t_qual();
    clear_flags();
    v = 1'b1; r = 1'b1; l = 1'b0; k = 4'hF; s = 4'h0; tick();
    k = 4'h0; s = 4'h0; tick();
    l = 1'b1; tick();
    v = 1'b0; tick();
    chk(flags, 4'h0, "R6 position and null transfers legal");
    chk(xc, exp_x, "R6 null transfers counted");
    chk(pc, exp_p, "R6 null last closes packet");
    k = 4'h0; s = 4'hF; tick();
    chk(flags, 4'h0, "R5 qualifiers ignored without valid");
    v = 1'b1; r = 1'b1; k = 4'b1110; s = 4'b0001; tick();
    v = 1'b0; k = 4'hF; s = 4'hF; tick();
    chk(flags, 4'h4, "R5 keep0 strobe1 on one byte");
  endtask

  task automatic t_tags();
    clear_flags();
    v = 1'b1; r = 1'b1; l = 1'b0; id = 4'h3; dst = 4'h5; tick();
    tick();
    id = 4'h6; l = 1'b1; tick();
    v = 1'b0; tick();
    chk(flags, 4'h8, "R7 id changed inside packet");
    clear_flags();
    v = 1'b1; r = 1'b1; id = 4'h9; dst = 4'h2; l = 1'b0; tick();
    dst = 4'h7; l = 1'b1; tick();
    v = 1'b0; tick();
    chk(flags, 4'h8, "R7 dest changed inside packet");
    clear_flags();
    v = 1'b1; r = 1'b1; id = 4'hC; dst = 4'h1; l = 1'b1; tick();
    v = 1'b0; tick();
    chk(flags, 4'h0, "R7 new tags at packet start legal");
  endtask

  task automatic t_mask_clear();
    clear_flags();
    mask = 4'h1;
    v = 1'b1; r = 1'b0; l = 1'b1; tick(); v = 1'b0; tick();
    chk(flags, 4'h0, "R8 masked drop silent");
    v = 1'b1; r = 1'b0; d = 32'h1; tick(); d = 32'h2; tick();
    chk(flags, 4'h2, "R8 unmasked class still detected");
    r = 1'b1; tick();
    mask = 4'h0;
    clear_flags();
    v = 1'b1; r = 1'b0; tick(); v = 1'b0; tick();
    tick(); tick();
    chk(flags, 4'h1, "R9 flag sticky while idle");
    v = 1'b1; r = 1'b0; tick();
    v = 1'b0; clr = 1'b1; tick(); clr = 1'b0;
    chk(flags, 4'h0, "R9 clear beats same-cycle error");
    tick();
    chk(flags, 4'h0, "R9 stays clear");
    chk(xc, exp_x, "R9 clear leaves xfer count");
    chk(pc, exp_p, "R10 packet count");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_handshake();
    t_drop();
    t_hold();
    t_qual();
    t_tags();
    t_mask_clear();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule